// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block sits between synchronous logic and an asynchronous static RAM with a 17-bit address, an 8-bit data bus, one active-low and one active-high chip select, an active-low write strobe and an active-low output enable. A one-cycle request carrying an address and a data byte is turned into a full write cycle on the RAM pins. Every analog interval of the RAM is turned into a whole number of clock cycles, rounded up from the clock period given in nanoseconds. The data bus is exposed as a value plus a drive enable, so the pad tristate stays outside the block.

The order of events is fixed. Address and both selects come first, then the write strobe falls, then the data driver turns on. The strobe then rises while the selects drop and the bus is released, and the cycle is padded to the minimum cycle time. A build parameter says whether output enable is held inactive during writes or tied active. In the tied case the RAM is still driving its outputs when the strobe falls. The driver therefore waits out the RAM's turn-off time, and the strobe is lengthened to match.

Top module: `sram_wr_seq`

## Requirements
- R1: After reset, the active-low select and the write strobe are high, the active-high select is low, the driver enable is low, and busy and done are low.
- R2: A request seen with busy low is accepted at that clock edge. Busy is high from the next cycle through the last cycle of the sequence. The RAM address equals the accepted address for the whole sequence.
- R3: Both selects are asserted for exactly one cycle before the write strobe falls. They stay asserted until the edge at which the strobe rises, and drop at that same edge.
- R4: The strobe is low for L cycles, where L is the largest of ceil(50/T), H+ceil(30/T) and ceil(60/T)-1. T is the clock period in ns, and H is ceil(25/T) when output enable is tied active, otherwise 0. With T=10 this gives L=5 in normal mode and L=6 in tied mode.
- R5: The driver enable is high only in the last L-H cycles of the strobe-low period, and the driven value is the accepted data byte.
- R6: The sequence lasts max(ceil(70/T), L+2) cycles, counted from the first select cycle and including at least one cycle with selects and strobe inactive. With T=10 this is 7 cycles in normal mode and 8 in tied mode.
- R7: Done is high for exactly one cycle, the last one of the sequence. A request presented in the following cycle is accepted.
- R8: A request arriving while busy is high changes neither the address, the pin sequence nor its length.
- R9: Output enable is held high when the tied-mode parameter is 0 and held low when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Single-cycle write request |
| req_addr | input | 17 | Write address |
| req_data | input | 8 | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last cycle of the sequence |
| sram_addr | output | 17 | RAM address pins |
| sram_cs_n | output | 1 | Active-low chip select |
| sram_cs | output | 1 | Active-high chip select |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| dq_out | output | 8 | Value for the data pads |
| dq_oe | output | 1 | Data pad drive enable |

## Verification
The hardest case is a request that arrives in the middle of a sequence. The design must drop it, and if the state machine took it by mistake, the error would only show as a shifted address or a stretched strobe. The bench raises a request with an inverted address two cycles into selected sequences and then compares every pin, every cycle, against a waveform it computes from the timing formulas. Tied-mode stretching is reached through a second instance built with output enable tied active. Back-to-back sequences check that the cycle after done accepts new work.

// File: rtl/sram_wr_seq.sv
module sram_wr_seq #(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 8,
  parameter int CLK_NS      = 10,
  parameter int OE_TIED_LOW = 0,
  parameter int T_WC_NS     = 70,
  parameter int T_AW_NS     = 60,
  parameter int T_WP_NS     = 50,
  parameter int T_DW_NS     = 30,
  parameter int T_WHZ_NS    = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_cs,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  localparam int L_WP   = (T_WP_NS + CLK_NS - 1) / CLK_NS;
  localparam int L_DW   = (T_DW_NS + CLK_NS - 1) / CLK_NS;
  localparam int L_AW   = (T_AW_NS + CLK_NS - 1) / CLK_NS;
  localparam int L_WC   = (T_WC_NS + CLK_NS - 1) / CLK_NS;
  localparam int L_HZ   = (OE_TIED_LOW != 0) ? (T_WHZ_NS + CLK_NS - 1) / CLK_NS : 0;
  localparam int L_A    = (L_WP > L_HZ + L_DW) ? L_WP : L_HZ + L_DW;
  localparam int L_B    = (L_A > L_AW - 1) ? L_A : L_AW - 1;
  localparam int L_LOW  = (L_B > 1) ? L_B : 1;
  localparam int L_DRV  = L_LOW - L_HZ;
  localparam int L_TAIL = (L_WC - 1 - L_LOW > 1) ? L_WC - 1 - L_LOW : 1;
  localparam int CNT_W  = $clog2(L_WC + L_LOW + 2);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_HIZ, S_DRIVE, S_TAIL} state_t;

  state_t             state;
  logic [CNT_W-1:0]   cnt;
  logic [DATA_W-1:0]  data_q;
  logic               sel_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      sram_addr <= '0;
      data_q    <= '0;
    end else begin
      case (state)
        S_IDLE: if (req) begin
          state     <= S_SETUP;
          cnt       <= '0;
          sram_addr <= req_addr;
          data_q    <= req_data;
        end
        S_SETUP: if (L_HZ > 0) begin
          state <= S_HIZ;
          cnt   <= CNT_W'(L_HZ - 1);
        end else begin
          state <= S_DRIVE;
          cnt   <= CNT_W'(L_DRV - 1);
        end
        S_HIZ: if (cnt == '0) begin
          state <= S_DRIVE;
          cnt   <= CNT_W'(L_DRV - 1);
        end else cnt <= cnt - 1'b1;
        S_DRIVE: if (cnt == '0) begin
          state <= S_TAIL;
          cnt   <= CNT_W'(L_TAIL - 1);
        end else cnt <= cnt - 1'b1;
        S_TAIL: if (cnt == '0) state <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign sel_on    = (state == S_SETUP) || (state == S_HIZ) || (state == S_DRIVE);
  assign sram_cs_n = !sel_on;
  assign sram_cs   = sel_on;
  assign sram_we_n = !((state == S_HIZ) || (state == S_DRIVE));
  assign sram_oe_n = (OE_TIED_LOW == 0);
  assign dq_oe     = (state == S_DRIVE);
  assign dq_out    = data_q;
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_TAIL) && (cnt == '0);

  AST_WE_INSIDE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_cs_n && sram_cs)); // R3
  AST_SEL_BEFORE_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> $past(!sram_cs_n && sram_cs && sram_we_n)); // R3
  AST_DRIVE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !sram_we_n); // R5
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(sram_addr)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && sram_we_n && !dq_oe)); // R6
endmodule

// File: tb/sram_wr_seq_tb.sv
module sram_wr_seq_tb;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  req = 2'b00;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic [1:0]  busy, done, cs_n, cs, we_n, oe_n, dq_oe;
  logic [16:0] addr [2];
  logic [7:0]  dqo  [2];
  int checks = 0;
  int errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  sram_wr_seq #(.CLK_NS(CLK_NS), .OE_TIED_LOW(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req[0]), .req_addr(req_addr), .req_data(req_data),
    .busy(busy[0]), .done(done[0]), .sram_addr(addr[0]), .sram_cs_n(cs_n[0]),
    .sram_cs(cs[0]), .sram_we_n(we_n[0]), .sram_oe_n(oe_n[0]), .dq_out(dqo[0]),
    .dq_oe(dq_oe[0]));

  sram_wr_seq #(.CLK_NS(CLK_NS), .OE_TIED_LOW(1)) u_dut_tied (
    .clk(clk), .rst_n(rst_n), .req(req[1]), .req_addr(req_addr), .req_data(req_data),
    .busy(busy[1]), .done(done[1]), .sram_addr(addr[1]), .sram_cs_n(cs_n[1]),
    .sram_cs(cs[1]), .sram_we_n(we_n[1]), .sram_oe_n(oe_n[1]), .dq_out(dqo[1]),
    .dq_oe(dq_oe[1]));

  function automatic int cdiv(input int t);
    return (t + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input string rq, input int d, input int k, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s dut%0d cycle %0d: actual %0h expected %0h", rq, d, k, act, exp);
    end
  endtask

  task automatic idle_pins(input string rq, input int d, input int k);
    chk(rq, d, k, cs_n[d], 1);
    chk(rq, d, k, cs[d], 0);
    chk(rq, d, k, we_n[d], 1);
    chk(rq, d, k, dq_oe[d], 0);
    chk(rq, d, k, busy[d], 0);
    chk(rq, d, k, done[d], 0);
  endtask

  task automatic do_write(input int d, input logic [16:0] a, input logic [7:0] v, input bit poke);
    int hz, low, n;
    bit sel, wl, drv;
    hz  = (d == 1) ? cdiv(25) : 0;
    low = imax(imax(cdiv(50), hz + cdiv(30)), cdiv(60) - 1);
    n   = imax(cdiv(70), low + 2);
    req_addr = a;
    req_data = v;
    req[d] = 1'b1;
    @(negedge clk);
    req[d] = 1'b0;
    req_addr = ~a;
    req_data = ~v;
    for (int k = 0; k < n; k++) begin
      sel = (k <= low);
      wl  = (k >= 1) && (k <= low);
      drv = (k >= 1 + hz) && (k <= low);
      chk("R2", d, k, busy[d], 1);
      chk("R2", d, k, addr[d], a);
      chk("R3", d, k, cs_n[d], !sel);
      chk("R3", d, k, cs[d], sel);
      chk("R4", d, k, we_n[d], !wl);
      chk("R5", d, k, dq_oe[d], drv);
      if (drv) chk("R5", d, k, dqo[d], v);
      chk("R6", d, k, done[d], (k == n - 1));
      chk("R7", d, k, done[d] && !(k == n - 1), 0);
      chk("R9", d, k, oe_n[d], (d == 0));
      if (poke && k == 2) req[d] = 1'b1; // R8
      if (poke && k == 3) req[d] = 1'b0;
      @(negedge clk);
    end
    chk("R7", d, n, busy[d], 0);
    chk("R8", d, n, cs_n[d], 1);
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int d = 0; d < 2; d++) idle_pins("R1", d, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      idle_pins("R1", d, 1);
      chk("R9", d, 1, oe_n[d], (d == 0));
    end
    for (int d = 0; d < 2; d++) begin
      do_write(d, 17'h00000, 8'h00, 1'b0);
      do_write(d, 17'h1FFFF, 8'hFF, 1'b1);
      for (int b = 0; b < 17; b++)
        do_write(d, 17'(1) << b, 8'(8'hA5 ^ b), (b % 3) == 0);
      for (int b = 0; b < 8; b++)
        do_write(d, ~(17'(1) << b), 8'(1) << b, b[0]);
      idle_pins("R7", d, 99);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule